// File: doc/BRIEF.md
# Soft-Start and Fault Supervisor

This block decides when a phase-shifted bridge sequencer may switch. It tracks supply undervoltage with hysteresis, watches a reference-good flag, an external disable request and a current-sense code. It also keeps a digital soft-start level that stands in for the voltage on a soft-start capacitor. The incoming control word is always limited to that level, so the duty command can only grow as fast as the level charges.

A supply or reference fault, or a disable request, drops the level to zero on the same clock edge. An overcurrent is handled differently. The block does not cut off at once. It drains the level at ten times the charge step per cycle. Once the level is below the minimum threshold, it clears the level and starts a complete soft start again. All decisions are made on one system clock, and every analog threshold is a code comparison.

Top module: `ss_supervisor`

## Requirements
- R1: Undervoltage lockout releases when `vdd_code_i` is at least UV_ON (default 110) and re-asserts when it is at most UV_OFF (default 90). Between these two codes the previous lockout decision holds.
- R2: When the supply is under lockout, `state_o` becomes LOCKOUT (code 0) and the soft-start level becomes 0 on that same clock edge.
- R3: With the supply good, a low `ref_ok_i` or a high `dis_req_i` moves `state_o` to DISABLED (code 4) and clears the level on that edge. When both conditions are gone, the next edge enters SOFT_START (code 1). Leaving LOCKOUT with a good reference also enters SOFT_START.
- R4: In SOFT_START and RUN the level grows by `step_i` on each edge and saturates at full scale (255 by default). The edge after the level reaches full scale moves SOFT_START to RUN (code 2).
- R5: A `cs_code_i` of at least OC_LIM (default 25) in SOFT_START or RUN moves the block to SOFT_STOP (code 3) with the level unchanged, and `soft_stop_o` is high exactly in SOFT_STOP. A code one below OC_LIM has no effect.
- R6: In SOFT_STOP the level falls by 10 x `step_i` on each edge and saturates at 0. Overcurrent is ignored during SOFT_STOP. On an edge where the level is below SS_MIN (default 5), the state becomes SOFT_START and the level becomes 0.
- R7: `ctrl_o` equals the smaller of `ctrl_i` and the current level, in every state, and responds to `ctrl_i` without a clock.
- R8: `run_en_o` is high only in SOFT_START or RUN, and only while the level is at or above SS_MIN.
- R9: `ref_en_o` is low only in LOCKOUT.
- R10: Priority on each edge runs supply lockout, then reference fault or disable request, then overcurrent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vdd_code_i | input | VW | Supply voltage code |
| ref_ok_i | input | 1 | Reference within limits |
| cs_code_i | input | CW | Current-sense code |
| dis_req_i | input | 1 | External disable request |
| step_i | input | SW | Soft-start charge step per cycle |
| ctrl_i | input | AW | Unclamped control word |
| run_en_o | output | 1 | Bridge switching permitted |
| ctrl_o | output | AW | Control word clamped to the soft-start level |
| ref_en_o | output | 1 | Reference enable |
| state_o | output | 3 | Supervisor state code |
| soft_stop_o | output | 1 | Soft stop in progress |

## Verification
With `ctrl_i` held at full scale, `ctrl_o` mirrors the soft-start level. A level that is wrong, whether from a bad step, a wrapped sum or a missed clear, therefore appears on the edge right after the cause. A state register that goes wrong shows on `state_o`, `run_en_o` and `ref_en_o` in the same cycle. The drain sequence after an overcurrent is checked edge by edge, down to the saturated zero and the following restart. The threshold codes are tested one code away from each boundary, where an off-by-one comparison would move a transition by one input step.

// File: rtl/ss_sup_pkg.sv
package ss_sup_pkg;
  typedef enum logic [2:0] {
    ST_LOCKOUT    = 3'd0,
    ST_SOFT_START = 3'd1,
    ST_RUN        = 3'd2,
    ST_SOFT_STOP  = 3'd3,
    ST_DISABLED   = 3'd4
  } sup_state_e;

  typedef enum logic [1:0] {
    ACC_HOLD   = 2'd0,
    ACC_CLEAR  = 2'd1,
    ACC_CHARGE = 2'd2,
    ACC_DRAIN  = 2'd3
  } acc_cmd_e;
endpackage

// File: rtl/ss_uvlo_hyst.sv
module ss_uvlo_hyst #(
  parameter int VW     = 8,
  parameter int UV_ON  = 110,
  parameter int UV_OFF = 90
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [VW-1:0] vdd_i,
  output logic          ok_next_o,
  output logic          ok_o
);
  logic ok_q;

  assign ok_next_o = ok_q ? (vdd_i > VW'(UV_OFF)) : (vdd_i >= VW'(UV_ON));
  assign ok_o      = ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_q <= 1'b0;
    else         ok_q <= ok_next_o;
  end

  assert_lock_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ok_q && vdd_i < VW'(UV_ON)) |=> !ok_q);
  assert_release_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q && vdd_i > VW'(UV_OFF)) |=> ok_q);
endmodule

// File: rtl/ss_accum.sv
module ss_accum
  import ss_sup_pkg::*;
#(
  parameter int AW         = 8,
  parameter int SW         = 4,
  parameter int DRAIN_MULT = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  acc_cmd_e      cmd_i,
  input  logic [SW-1:0] step_i,
  output logic [AW-1:0] level_o
);
  localparam int WW      = AW + SW + 5;
  localparam int LVL_MAX = (1 << AW) - 1;

  logic [AW-1:0] level_q, level_d;
  logic [WW-1:0] lvl_w, up_w, drain_w;

  always_comb begin
    lvl_w   = WW'(level_q);
    up_w    = lvl_w + WW'(step_i);
    drain_w = WW'(step_i) * WW'(DRAIN_MULT);
    level_d = level_q;
    unique case (cmd_i)
      ACC_CLEAR:  level_d = '0;
      ACC_CHARGE: level_d = (up_w > WW'(LVL_MAX)) ? AW'(LVL_MAX) : up_w[AW-1:0];
      ACC_DRAIN:  level_d = (drain_w >= lvl_w) ? '0 : AW'(lvl_w - drain_w);
      default:    level_d = level_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= level_d;
  end

  assign level_o = level_q;

  assert_charge_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == ACC_CHARGE) |=> level_q >= $past(level_q));
  assert_drain_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == ACC_DRAIN) |=> level_q <= $past(level_q));
endmodule

// File: rtl/ss_ctrl_fsm.sv
module ss_ctrl_fsm
  import ss_sup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       ref_ok_i,
  input  logic       dis_req_i,
  input  logic       oc_i,
  input  logic       level_full_i,
  input  logic       level_low_i,
  output sup_state_e state_o,
  output acc_cmd_e   cmd_o
);
  sup_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    cmd_o   = ACC_HOLD;
    if (!supply_ok_i) begin
      state_d = ST_LOCKOUT;
      cmd_o   = ACC_CLEAR;
    end else if (!ref_ok_i || dis_req_i) begin
      state_d = ST_DISABLED;
      cmd_o   = ACC_CLEAR;
    end else begin
      unique case (state_q)
        ST_LOCKOUT, ST_DISABLED: state_d = ST_SOFT_START;
        ST_SOFT_START: begin
          if (oc_i) state_d = ST_SOFT_STOP;
          else begin
            cmd_o = ACC_CHARGE;
            if (level_full_i) state_d = ST_RUN;
          end
        end
        ST_RUN: begin
          if (oc_i) state_d = ST_SOFT_STOP;
          else      cmd_o   = ACC_CHARGE;
        end
        ST_SOFT_STOP: begin
          if (level_low_i) begin
            state_d = ST_SOFT_START;
            cmd_o   = ACC_CLEAR;
          end else begin
            cmd_o = ACC_DRAIN;
          end
        end
        default: begin
          state_d = ST_LOCKOUT;
          cmd_o   = ACC_CLEAR;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOCKOUT;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_stop_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SOFT_STOP && supply_ok_i && ref_ok_i && !dis_req_i)
    |=> (state_q == ST_SOFT_STOP || state_q == ST_SOFT_START));
  assert_oc_enters_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && oc_i && supply_ok_i && ref_ok_i && !dis_req_i)
    |=> state_q == ST_SOFT_STOP);
endmodule

// File: rtl/ss_supervisor.sv
module ss_supervisor
  import ss_sup_pkg::*;
#(
  parameter int VW         = 8,
  parameter int CW         = 8,
  parameter int AW         = 8,
  parameter int SW         = 4,
  parameter int UV_ON      = 110,
  parameter int UV_OFF     = 90,
  parameter int OC_LIM     = 25,
  parameter int SS_MIN     = 5,
  parameter int DRAIN_MULT = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [VW-1:0] vdd_code_i,
  input  logic          ref_ok_i,
  input  logic [CW-1:0] cs_code_i,
  input  logic          dis_req_i,
  input  logic [SW-1:0] step_i,
  input  logic [AW-1:0] ctrl_i,
  output logic          run_en_o,
  output logic [AW-1:0] ctrl_o,
  output logic          ref_en_o,
  output logic [2:0]    state_o,
  output logic          soft_stop_o
);
  logic          supply_ok_next, supply_ok_q;
  logic [AW-1:0] level;
  logic          level_low, level_full, oc;
  sup_state_e    state;
  acc_cmd_e      cmd;

  ss_uvlo_hyst #(.VW(VW), .UV_ON(UV_ON), .UV_OFF(UV_OFF)) u_uvlo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vdd_i     (vdd_code_i),
    .ok_next_o (supply_ok_next),
    .ok_o      (supply_ok_q)
  );

  ss_accum #(.AW(AW), .SW(SW), .DRAIN_MULT(DRAIN_MULT)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd),
    .step_i  (step_i),
    .level_o (level)
  );

  assign level_low  = level < AW'(SS_MIN);
  assign level_full = &level;
  assign oc         = cs_code_i >= CW'(OC_LIM);

  ss_ctrl_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .supply_ok_i  (supply_ok_next),
    .ref_ok_i     (ref_ok_i),
    .dis_req_i    (dis_req_i),
    .oc_i         (oc),
    .level_full_i (level_full),
    .level_low_i  (level_low),
    .state_o      (state),
    .cmd_o        (cmd)
  );

  assign ctrl_o      = (ctrl_i < level) ? ctrl_i : level;
  assign run_en_o    = (state == ST_SOFT_START || state == ST_RUN) && !level_low;
  assign ref_en_o    = (state != ST_LOCKOUT);
  assign soft_stop_o = (state == ST_SOFT_STOP);
  assign state_o     = state;

  assert_lockout_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vdd_code_i <= VW'(UV_OFF)) |=> (state_o == ST_LOCKOUT && level == '0 && !run_en_o));
  assert_ref_fault_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vdd_code_i >= VW'(UV_ON) && !ref_ok_i) |=> (state_o == ST_DISABLED && level == '0));
  assert_stop_no_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_stop_o |-> !run_en_o);
  assert_ref_only_lockout_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_en_o |-> !supply_ok_q);
endmodule

// File: tb/ss_supervisor_bench.sv
`timescale 1ns/1ps
module ss_supervisor_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] vdd = 8'd0;
  logic       ref_ok = 1'b1;
  logic [7:0] cs = 8'd0;
  logic       dis = 1'b0;
  logic [3:0] step = 4'd10;
  logic [7:0] ctrl_in = 8'd255;
  logic       run_en, ref_en, soft_stop;
  logic [7:0] ctrl_out;
  logic [2:0] state;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ss_supervisor u_ss_supervisor (
    .clk_i(clk), .rst_ni(rst_ni), .vdd_code_i(vdd), .ref_ok_i(ref_ok),
    .cs_code_i(cs), .dis_req_i(dis), .step_i(step), .ctrl_i(ctrl_in),
    .run_en_o(run_en), .ctrl_o(ctrl_out), .ref_en_o(ref_en),
    .state_o(state), .soft_stop_o(soft_stop)
  );

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R2 reset state", state, 0);
    check("R2 reset level", ctrl_out, 0);
    check("R8 reset run_en", run_en, 0);
    check("R9 reset ref_en", ref_en, 0);
    check("R5 reset soft_stop", soft_stop, 0);
  endtask

  task automatic t_power_up();
    vdd = 8'd109; tick();
    check("R1 below release stays locked", state, 0);
    vdd = 8'd110; tick();
    check("R1 release to soft start", state, 1);
    check("R4 level at entry", ctrl_out, 0);
    check("R8 run_en off below min", run_en, 0);
    check("R9 ref_en on", ref_en, 1);
    tick();
    check("R4 first step", ctrl_out, 10);
    check("R8 run_en on at min", run_en, 1);
    vdd = 8'd91; tick();
    check("R1 hysteresis holds", state, 1);
    check("R4 second step", ctrl_out, 20);
    ctrl_in = 8'd3; #1;
    check("R7 clamp passes small word", ctrl_out, 3);
    ctrl_in = 8'd255; #1;
    check("R7 clamp to level", ctrl_out, 20);
  endtask

  task automatic t_charge();
    int n = 0;
    int mono = 1;
    int prev = ctrl_out;
    for (int i = 0; i < 40; i++) begin
      tick(); n++;
      if (ctrl_out < prev) mono = 0;
      prev = ctrl_out;
      if (ctrl_out == 255) break;
    end
    check("R4 monotonic charge", mono, 1);
    check("R4 edges to full scale", n, 24);
    check("R4 saturated level", ctrl_out, 255);
    check("R4 still soft start at full", state, 1);
    tick();
    check("R4 enter run", state, 2);
    check("R4 level stays full", ctrl_out, 255);
    ctrl_in = 8'd100; #1;
    check("R7 run passes word", ctrl_out, 100);
    ctrl_in = 8'd255;
  endtask

  task automatic t_overcurrent();
    cs = 8'd24; tick();
    check("R5 below limit no effect", state, 2);
    cs = 8'd25; tick();
    check("R5 enter soft stop", state, 3);
    check("R5 level unchanged", ctrl_out, 255);
    check("R5 soft_stop flag", soft_stop, 1);
    check("R8 run_en off in stop", run_en, 0);
    cs = 8'd30; tick();
    check("R6 drain 1", ctrl_out, 155);
    check("R6 oc ignored in stop", state, 3);
    cs = 8'd0; tick();
    check("R6 drain 2", ctrl_out, 55);
    tick();
    check("R6 drain saturates at zero", ctrl_out, 0);
    check("R6 still stopping", state, 3);
    tick();
    check("R6 restart soft start", state, 1);
    check("R6 restart level", ctrl_out, 0);
    check("R5 soft_stop cleared", soft_stop, 0);
    tick();
    check("R6 full soft start resumes", ctrl_out, 10);
  endtask

  task automatic t_ref_disable();
    ref_ok = 1'b0; tick();
    check("R3 ref fault disables", state, 4);
    check("R3 ref fault clears level", ctrl_out, 0);
    check("R8 run_en off disabled", run_en, 0);
    check("R9 ref_en on disabled", ref_en, 1);
    ref_ok = 1'b1; dis = 1'b1; cs = 8'd25; tick();
    check("R10 disable beats overcurrent", state, 4);
    dis = 1'b0; cs = 8'd0; tick();
    check("R3 leave disabled", state, 1);
    tick();
    check("R3 charging after disable", ctrl_out, 10);
    tick();
    check("R4 charge", ctrl_out, 20);
  endtask

  task automatic t_lockout();
    ref_ok = 1'b0; vdd = 8'd90; tick();
    check("R10 supply beats reference", state, 0);
    check("R2 lockout clears level", ctrl_out, 0);
    check("R9 ref_en off in lockout", ref_en, 0);
    ref_ok = 1'b1; vdd = 8'd100; tick();
    check("R1 between thresholds stays locked", state, 0);
    vdd = 8'd110; tick();
    check("R3 release to soft start", state, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_power_up();
    t_charge();
    t_overcurrent();
    t_ref_disable();
    t_lockout();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule